// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is a master-only serial shift engine that sits behind four small registers. Software picks the idle clock level, the sampling phase, a character length from 1 to 16 bits, an internal loopback path and a run bit that doubles as a soft reset. Each write to the data register queues one character. The engine shifts the character out MSB-first from a left-justified word and collects the incoming bits right-justified. It then raises a completion flag, and sets an overrun flag when a second character finishes before the first was read.

The serial clock comes from the system clock through an even divider set in a separate register. Chip-select stays low for the whole character. While the run bit is clear, the operating flags are held at zero and the serial clock is forced low whatever the idle level. Data written in that state is dropped. After the run bit is set, the serial clock stays low for one full serial period before it settles at its idle level and transfers can begin.

The register map has four entries. CTRL (addr 0) holds len [3:0], phase [4], polarity [5], loopback [6], a reserved bit [7] and run [8]. BAUD (addr 1) holds the divider field. DATA (addr 2) takes the transmit word on a write and returns the receive word on a read. STAT (addr 3) holds complete [0], overrun [1] and tx-full [2]. A read returns the addressed register combinationally, and a read of DATA with rd_en high clears the complete flag.

Top module: `spi_master_engine`

## Requirements
- R1: After hardware reset, sclk_o is 0, cs_n_o is 1, and both STAT and CTRL read as 0.
- R2: Clearing the run bit (CTRL[8]) leaves every other CTRL field as written; reading CTRL returns them unchanged.
- R3: While run is 0, the complete, overrun and tx-full bits of STAT read 0 and cs_n_o is 1.
- R4: A DATA write made while run is 0 is discarded: no character starts after run is set, and tx-full stays 0.
- R5: While run is 0, sclk_o is 0 even with polarity (CTRL[5]) set to 1. After run is set, sclk_o stays 0 for one serial period (two half periods) and then takes the polarity value.
- R6: The idle sclk_o level equals polarity. The sample edge is the leading edge (the one leaving idle) when phase (CTRL[4]) is 0, and the trailing edge when phase is 1. The outgoing bit changes on the other edge, and the first bit is valid from the moment chip-select falls.
- R7: A character is len+1 bits long (len = CTRL[3:0]). The bits of DATA[15] downward are sent, and the received bits appear right-justified in DATA with zeros above.
- R8: With loopback (CTRL[6]) set, the received character equals the transmitted bits and miso_i is ignored.
- R9: STAT[0] sets when the last bit is sampled and clears when DATA is read. If a character completes while STAT[0] is still set, STAT[1] (overrun) sets and the newer character replaces the receive word.
- R10: STAT[2] is 1 from a DATA write until the engine takes that word into its shifter. A write made during a transfer keeps it at 1 until the current character ends.
- R11: CTRL[7] is reserved. It reads 0 whatever was written to it.
- R12: One serial period lasts 2*(B+1) system clocks, where B is BAUD[7:0] and values below 1 are treated as 1 (minimum divide of 4).
- R13: Chip-select is low across every clock edge of a character. A character of N bits shows exactly 2N sclk_o edges while cs_n_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for write and read |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe (read side effects) |
| rd_data | output | 16 | Addressed register contents |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Active-low chip-select |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A slave model follows the serial lines in all four clock modes and at lengths of 1, 5, 8 and 16 bits. A mix-up between the leading and trailing edge would show as a word shifted by one bit, and a missing left-justification would send the low byte instead of the high one. The bench times the low period of the serial clock after the run bit is set, so a design that goes straight to the idle level gets caught, and it keeps polarity at 1 during soft reset to catch a clock that follows polarity. It writes data during soft reset and then watches for a stray chip-select, which exposes a design that keeps the stale word. Back-to-back and unread characters exercise the tx-full hold, the overrun flag and the ordering of the receive word, and the divider is also checked at its clamped minimum.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_BAUD = 2'd1,
    REG_DATA = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  localparam int ST_DONE = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_TXF  = 2;

  // system clocks per serial half period; divider field below 1 clamps to 1
  function automatic int unsigned half_len(input int unsigned baud);
    return (baud < 2) ? 2 : baud + 1;
  endfunction

  // bits per character from the length field
  function automatic int unsigned char_bits(input int unsigned len_field);
    return len_field + 1;
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick
  import spi_eng_pkg::*;
#(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic [BAUD_W-1:0] baud_i,
  output logic              tick_o
);
  localparam int CW = BAUD_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit  = CW'(half_len(32'(baud_i)) - 32'd1);
  assign tick_o = !restart_i && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (restart_i || tick_o)   cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  // R12
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              cpha_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sclk_lvl_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_capt_o
);
  localparam int NB_W  = LEN_W + 1;
  localparam int CNT_W = LEN_W + 2;

  logic [CNT_W-1:0]  edge_q;
  logic [NB_W-1:0]   samp_q;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [NB_W-1:0]   n_bits;
  logic [CNT_W-1:0]  n_edges;
  logic step, last_tick, lead_edge, samp_edge;

  assign n_bits    = NB_W'(char_bits(32'(len_i)));
  assign n_edges   = {n_bits, 1'b0};
  assign step      = busy_o && tick_i && (edge_q != n_edges);
  assign last_tick = busy_o && tick_i && (edge_q == n_edges);
  assign lead_edge = ~edge_q[0];
  assign samp_edge = cpha_i ? ~lead_edge : lead_edge;
  assign done_o    = step && samp_edge && (samp_q == n_bits - 1'b1);
  assign rx_capt_o = {rx_sh[DATA_W-2:0], miso_i};
  assign mosi_o    = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      cs_n_o     <= 1'b1;
      sclk_lvl_o <= 1'b0;
      edge_q     <= '0;
      samp_q     <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
    end else if (!run_i) begin
      busy_o     <= 1'b0;
      cs_n_o     <= 1'b1;
      sclk_lvl_o <= 1'b0;
    end else if (start_i) begin
      busy_o     <= 1'b1;
      cs_n_o     <= 1'b0;
      sclk_lvl_o <= 1'b0;
      edge_q     <= '0;
      samp_q     <= '0;
      tx_sh      <= tx_word_i;
      rx_sh      <= '0;
    end else if (last_tick) begin
      busy_o <= 1'b0;
      cs_n_o <= 1'b1;
    end else if (step) begin
      edge_q     <= edge_q + 1'b1;
      sclk_lvl_o <= ~sclk_lvl_o;
      if (samp_edge) begin
        rx_sh  <= rx_capt_o;
        samp_q <= samp_q + 1'b1;
      end else if (samp_q != '0 && samp_q != n_bits) begin
        tx_sh <= tx_sh << 1;
      end
    end
  end

  // R13
  cs_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !cs_n_o);

  // R7
  all_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |-> (samp_q == n_bits));

endmodule

// File: rtl/spi_master_engine.sv
module spi_master_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int B_CPHA = LEN_W;
  localparam int B_CPOL = LEN_W + 1;
  localparam int B_LOOP = LEN_W + 2;
  localparam int B_RSV  = LEN_W + 3;
  localparam int B_RUN  = LEN_W + 4;

  logic             ctrl_run, ctrl_loop, ctrl_cpol, ctrl_cpha;
  logic [LEN_W-1:0] ctrl_len;
  logic [BAUD_W-1:0] baud_q;
  logic [DATA_W-1:0] tx_buf, rx_reg;
  logic int_flag, ovr_flag, tx_full;
  logic parked, park_half;

  logic wr_ctrl, wr_baud, wr_dat, rd_clr;
  logic tick, start, restart;
  logic core_busy, core_sclk, core_cs_n, core_mosi, char_done, miso_eff;
  logic [DATA_W-1:0] rx_capt;

  assign wr_ctrl = wr_en && (addr == REG_CTRL);
  assign wr_baud = wr_en && (addr == REG_BAUD);
  assign wr_dat  = wr_en && (addr == REG_DATA) && ctrl_run;
  assign rd_clr  = rd_en && (addr == REG_DATA);

  assign start    = ctrl_run && !parked && !core_busy && tx_full;
  assign restart  = !ctrl_run || start;
  assign miso_eff = ctrl_loop ? core_mosi : miso_i;

  // configuration survives the soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_run  <= 1'b0;
      ctrl_loop <= 1'b0;
      ctrl_cpol <= 1'b0;
      ctrl_cpha <= 1'b0;
      ctrl_len  <= '0;
      baud_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_len  <= wr_data[LEN_W-1:0];
        ctrl_cpha <= wr_data[B_CPHA];
        ctrl_cpol <= wr_data[B_CPOL];
        ctrl_loop <= wr_data[B_LOOP];
        ctrl_run  <= wr_data[B_RUN];
      end
      if (wr_baud) baud_q <= wr_data[BAUD_W-1:0];
    end
  end

  // operating flags, held clear while not running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_flag <= 1'b0;
      ovr_flag <= 1'b0;
      tx_full  <= 1'b0;
      tx_buf   <= '0;
      rx_reg   <= '0;
    end else if (!ctrl_run) begin
      int_flag <= 1'b0;
      ovr_flag <= 1'b0;
      tx_full  <= 1'b0;
    end else begin
      if (wr_dat) begin
        tx_buf  <= wr_data;
        tx_full <= 1'b1;
      end else if (start) begin
        tx_full <= 1'b0;
      end
      if (char_done) begin
        rx_reg   <= rx_capt;
        int_flag <= 1'b1;
        if (int_flag && !rd_clr) ovr_flag <= 1'b1;
      end else if (rd_clr) begin
        int_flag <= 1'b0;
      end
    end
  end

  // serial clock held low for two half periods after release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked    <= 1'b1;
      park_half <= 1'b0;
    end else if (!ctrl_run) begin
      parked    <= 1'b1;
      park_half <= 1'b0;
    end else if (parked && tick) begin
      if (park_half) parked <= 1'b0;
      park_half <= ~park_half;
    end
  end

  spi_half_tick #(.BAUD_W(BAUD_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .baud_i    (baud_q),
    .tick_o    (tick)
  );

  spi_shift_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (ctrl_run),
    .tick_i     (tick),
    .start_i    (start),
    .cpha_i     (ctrl_cpha),
    .len_i      (ctrl_len),
    .tx_word_i  (tx_buf),
    .miso_i     (miso_eff),
    .busy_o     (core_busy),
    .sclk_lvl_o (core_sclk),
    .cs_n_o     (core_cs_n),
    .mosi_o     (core_mosi),
    .done_o     (char_done),
    .rx_capt_o  (rx_capt)
  );

  assign sclk_o = (ctrl_run && !parked) ? (ctrl_cpol ^ core_sclk) : 1'b0;
  assign cs_n_o = core_cs_n | !ctrl_run;
  assign mosi_o = core_mosi;

  always_comb begin
    rd_data = '0;
    unique case (addr)
      REG_CTRL: begin
        rd_data[LEN_W-1:0] = ctrl_len;
        rd_data[B_CPHA]    = ctrl_cpha;
        rd_data[B_CPOL]    = ctrl_cpol;
        rd_data[B_LOOP]    = ctrl_loop;
        rd_data[B_RSV]     = 1'b0;
        rd_data[B_RUN]     = ctrl_run;
      end
      REG_BAUD: rd_data[BAUD_W-1:0] = baud_q;
      REG_DATA: rd_data = rx_reg;
      REG_STAT: begin
        rd_data[ST_DONE] = int_flag;
        rd_data[ST_OVR]  = ovr_flag;
        rd_data[ST_TXF]  = tx_full;
      end
      default: rd_data = '0;
    endcase
  end

  // R3
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_run |=> (!int_flag && !ovr_flag && !tx_full));

  // R5
  sclk_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_run) |-> (sclk_o == 1'b0) && parked);

  // R9
  ovr_needs_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(int_flag));

  // R13
  cs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_run && !parked && (sclk_o != ctrl_cpol)) |-> !cs_n_o);

endmodule

// File: tb/spi_master_engine_bench.sv
module spi_master_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] rd_data;
  logic sclk, cs_n, mosi;
  logic miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_master_engine u_spi_master_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sclk_o(sclk), .cs_n_o(cs_n),
    .mosi_o(mosi), .miso_i(miso)
  );

  int checks = 0, fails = 0;
  int cfg_cpol = 0, cfg_cpha = 0, cfg_nb = 8, cfg_half = 2;
  bit cfg_loop = 0;
  logic [15:0] slv_val = 16'd0;
  logic [15:0] q_mosi[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int len_f, bit cpha, bit cpol, bit loop, bit rsv, bit run);
    logic [15:0] v;
    v = 16'(len_f) & 16'h000F;
    v[4] = cpha; v[5] = cpol; v[6] = loop; v[7] = rsv; v[8] = run;
    return v;
  endfunction

  function automatic logic [15:0] low_bits(logic [15:0] v, int nb);
    logic [16:0] m;
    m = (17'd1 << nb) - 17'd1;
    return v & m[15:0];
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // slave model and scoreboard monitor
  int cyc = 0;
  always @(posedge clk) cyc++;
  logic pv_sclk = 1'b0, pv_cs = 1'b1;
  int m_edges = 0, m_samp = 0, last_lead = -1, cs_falls = 0;
  logic [15:0] m_got = 16'd0;
  logic [15:0] m_exp;
  bit per_bad = 0, lead = 0;

  always @(negedge clk) begin
    if (pv_cs && !cs_n) begin
      cs_falls++;
      m_edges = 0; m_samp = 0; m_got = 16'd0; per_bad = 0; last_lead = -1;
      miso = slv_val[cfg_nb-1];
    end else if (!pv_cs && cs_n) begin
      if (q_mosi.size() == 0) begin
        chk(1'b0, "R13 unexpected character", 32'(m_got), 32'd0);
      end else begin
        m_exp = q_mosi.pop_front();
        chk(m_got == m_exp, "R6 mosi bits", 32'(m_got), 32'(m_exp));
        chk(m_edges == 2*cfg_nb, "R13 edge count", 32'(m_edges), 32'(2*cfg_nb));
        chk(!per_bad, "R12 serial period", 32'(per_bad), 32'd0);
      end
    end else if (!cs_n && (sclk != pv_sclk)) begin
      m_edges++;
      lead = (sclk != cfg_cpol[0]);
      if (lead) begin
        if (last_lead >= 0 && (cyc - last_lead) != 2*cfg_half) per_bad = 1;
        last_lead = cyc;
      end
      if (lead ^ cfg_cpha[0]) begin
        m_got = {m_got[14:0], mosi};
        m_samp++;
      end else if (m_samp > 0 && m_samp < cfg_nb) begin
        miso = slv_val[cfg_nb-1-m_samp];
      end
    end
    pv_cs = cs_n;
    pv_sclk = sclk;
  end

  task automatic set_cfg(int cpol, int cpha, int nb, bit loop);
    cfg_cpol = cpol; cfg_cpha = cpha; cfg_nb = nb; cfg_loop = loop;
    wr(2'd0, mk(nb-1, cpha[0], cpol[0], loop, 1'b0, 1'b1));
    repeat (4*cfg_half + 4) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [15:0] s;
    int g = 0;
    do begin rd(2'd3, s); g++; end while (!s[0] && g < 5000);
    while (!cs_n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] tx, input logic [15:0] slv, input string tag);
    logic [15:0] exp_rx, r;
    slv_val = slv;
    q_mosi.push_back(tx >> (16 - cfg_nb));
    exp_rx = cfg_loop ? (tx >> (16 - cfg_nb)) : low_bits(slv, cfg_nb);
    wr(2'd2, tx);
    wait_done();
    rd(2'd2, r);
    chk(r == exp_rx, tag, 32'(r), 32'(exp_rx));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r, e;
    int base;
    logic [15:0] tx_pat [4] = '{16'hA55A, 16'h3CC3, 16'h0FF0, 16'h8001};
    logic [15:0] sl_pat [4] = '{16'h00C3, 16'h0096, 16'h007E, 16'h0001};

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 32'd0);
    chk(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 32'd1);
    rd(2'd3, r); chk(r == 16'd0, "R1 stat", 32'(r), 32'd0);
    rd(2'd0, r); chk(r == 16'd0, "R1 ctrl", 32'(r), 32'd0);

    wr(2'd1, 16'd1); cfg_half = 2;
    // R5: polarity 1 but held in soft reset
    wr(2'd0, mk(7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    repeat (6) @(negedge clk);
    chk(sclk == 1'b0, "R5 sclk low in reset", 32'(sclk), 32'd0);
    rd(2'd0, r); e = mk(7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(r == e, "R2 ctrl readback", 32'(r), 32'(e));
    wr(2'd0, mk(7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R5 sclk low one period", 32'(sclk), 32'd0);
    @(negedge clk);
    chk(sclk == 1'b1, "R5 sclk idle after release", 32'(sclk), 32'd1);

    // R6: four clock modes
    for (int m = 0; m < 4; m++) begin
      set_cfg(m / 2, m % 2, 8, 1'b0);
      chk(sclk == 1'(m / 2), "R6 idle level", 32'(sclk), 32'(m / 2));
      xfer(tx_pat[m], sl_pat[m], "R6 rx word");
    end

    // R7: character lengths
    set_cfg(0, 0, 1, 1'b0);  xfer(16'h8000, 16'h0001, "R7 len1");
    set_cfg(1, 1, 16, 1'b0); xfer(16'hBEEF, 16'h1234, "R7 len16");
    set_cfg(0, 1, 5, 1'b0);  xfer(16'hB800, 16'h0013, "R7 len5");

    // R12: divider settings (period checked by monitor)
    wr(2'd1, 16'd3); cfg_half = 4;
    set_cfg(0, 0, 8, 1'b0); xfer(16'h6900, 16'h0055, "R12 baud3");
    wr(2'd1, 16'd0); cfg_half = 2;
    set_cfg(1, 0, 8, 1'b0); xfer(16'h9600, 16'h00AA, "R12 baud0");

    // R8: loopback ignores miso
    set_cfg(0, 0, 8, 1'b1); xfer(16'hC300, 16'h00FF, "R8 loopback");
    set_cfg(0, 0, 8, 1'b0);

    // R9: read clears complete; unread completion sets overrun
    rd(2'd3, r); chk(r[0] == 1'b0, "R9 cleared by read", 32'(r), 32'd0);
    slv_val = 16'h0011; q_mosi.push_back(16'h0071);
    wr(2'd2, 16'h7100); wait_done();
    rd(2'd3, r); chk(r[1:0] == 2'b01, "R9 complete set", 32'(r), 32'd1);
    slv_val = 16'h0022; q_mosi.push_back(16'h0072);
    wr(2'd2, 16'h7200); wait_done();
    rd(2'd3, r); chk(r[1:0] == 2'b11, "R9 overrun set", 32'(r), 32'd3);
    rd(2'd2, r); chk(r == 16'h0022, "R9 newer word kept", 32'(r), 32'h22);

    // R10: tx-full held across a busy transfer
    slv_val = 16'h0042; base = cs_falls;
    q_mosi.push_back(16'h0081); q_mosi.push_back(16'h0082);
    wr(2'd2, 16'h8100); wr(2'd2, 16'h8200);
    rd(2'd3, r); chk(r[2] == 1'b1, "R10 full while busy", 32'(r[2]), 32'd1);
    while (cs_falls < base + 2) @(negedge clk);
    while (!cs_n) @(negedge clk);
    rd(2'd3, r); chk(r[2] == 1'b0, "R10 full cleared", 32'(r[2]), 32'd0);
    rd(2'd2, r); chk(r == 16'h0042, "R10 second word", 32'(r), 32'h42);

    // R3 and R2: soft reset clears flags, keeps config
    wr(2'd0, mk(7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    rd(2'd3, r); chk(r == 16'd0, "R3 flags cleared", 32'(r), 32'd0);
    chk(cs_n == 1'b1, "R3 cs inactive", 32'(cs_n), 32'd1);
    rd(2'd0, r); e = mk(7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(r == e, "R2 config kept", 32'(r), 32'(e));

    // R4: write during soft reset is dropped
    wr(2'd2, 16'hFFFF);
    base = cs_falls;
    wr(2'd0, mk(7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    repeat (60) @(negedge clk);
    chk(cs_falls == base, "R4 no stray character", 32'(cs_falls), 32'(base));
    rd(2'd3, r); chk(r == 16'd0, "R4 tx-full clear", 32'(r), 32'd0);
    xfer(16'h5A00, 16'h00A5, "R4 new write runs");

    // R11: reserved bit reads zero
    wr(2'd0, mk(7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    rd(2'd0, r); chk(r[7] == 1'b0, "R11 reserved", 32'(r[7]), 32'd0);

    repeat (10) @(negedge clk);
    chk(q_mosi.size() == 0, "R13 all characters seen", 32'(q_mosi.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule